// File: doc/BRIEF.md
# Mode-Programmed Read Burst Sequencer

This block produces the read-side column sequence of a burst-oriented graphics memory. A mode-set command takes the burst length, the burst ordering and the read latency from the command address bus and holds them in a mode register. Each later READ command carries a column address. After the programmed latency, the block emits one column address per clock for the length of the burst, with a valid flag and the data word that the memory array returns for that beat.

Every burst covers an aligned block of four or eight columns. The two lowest column bits on the bus are ignored. A length-8 burst that starts in the upper half of its block runs through the upper four columns first and then wraps to the lower four. Column bits above the block are carried through unchanged. Illegal mode settings and READs that would overlap the burst already running are refused with a one-cycle error pulse. In both cases the block's state is left as it was.

Top module: `rd_burst_seq`

## Requirements
- R1: After reset the mode is burst length 4, sequential order, latency 4. `beat_valid`, `mode_err` and `read_err` are low, and no beats appear until a READ is accepted.
- R2: A mode-set command (`cmd_op` = 1) whose fields are legal updates the mode with no error. Field positions: `cmd_addr[2:0]` is the length code (3'b010 = 4, 3'b011 = 8), `cmd_addr[3]` is the ordering (0 = sequential), `cmd_addr[6:4]` is the latency in clocks (4 to 7).
- R3: A mode-set command with a reserved length code, with ordering bit 1, or with latency 0 to 3 raises `mode_err` for one cycle after its edge. The previous mode stays in force.
- R4: Suppose a READ (`cmd_op` = 2) is accepted at clock edge n and the latency is m. Then the first beat is visible after edge n+m, and `beat_valid` is low after edges n+1 .. n+m-1.
- R5: In a length-4 burst the low two column bits run 0,1,2,3, whatever `cmd_addr[1:0]` held.
- R6: In a length-8 burst the low three bits run 0..7 when READ column bit 2 is 0. They run 4,5,6,7,0,1,2,3 when that bit is 1.
- R7: Column bits above the burst block equal the READ column's bits on every beat.
- R8: `beat_valid` stays high for exactly as many consecutive cycles as the burst length.
- R9: A READ that arrives 1 to length-1 cycles after an accepted READ is refused. `read_err` pulses after its edge and the READ produces no beats. A READ exactly one burst length later is accepted, and its beats follow the earlier ones with no gap.
- R10: While an accepted READ has beats still to come, other than the final beat, a mode-set command is refused with `mode_err` and the mode is unchanged.
- R11: On each beat, `beat_data` equals the `rd_din` value that was present just before that beat's edge. When no beat is valid it is zero.
- R12: With `cmd_valid` low, `cmd_op` and `cmd_addr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 none, 1 mode set, 2 read |
| cmd_addr | input | 12 | Mode fields or read column |
| rd_din | input | 16 | Data word returned by the array |
| beat_col | output | 9 | Column address of the current beat |
| beat_data | output | 16 | Data of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| mode_err | output | 1 | Refused mode-set pulse |
| read_err | output | 1 | Refused READ pulse |

## Verification
The hardest case to reach is two READs that meet exactly at a burst boundary while the latency pipeline still holds the first one. It has to be set up so that the hand-over from the first burst to the second shows as eight unbroken beats. The bench issues the second READ exactly four cycles after the first and checks both column sequences beat by beat. It then places a second READ two cycles after a first one and checks that only four beats appear in the window that follows. A mode-set command is also issued while a read is still inside the latency pipeline, and a later read confirms that the old length and latency survived.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_MODE = 2'd1,
    OP_READ = 2'd2
  } cmd_op_e;

  localparam logic [2:0] LEN4_CODE = 3'b010;
  localparam logic [2:0] LEN8_CODE = 3'b011;
  localparam int unsigned ORDER_BIT = 3;
  localparam int unsigned LAT_LSB   = 4;
endpackage

// File: rtl/rbs_mode_reg.sv
module rbs_mode_reg #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CL_W   = 3,
  parameter int unsigned CL_MIN = 4,
  parameter int unsigned CL_MAX = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] fields,
  output logic              len8,
  output logic [CL_W-1:0]   lat,
  output logic              err
);
  import rbs_pkg::*;

  logic [2:0]    len_code;
  logic [CL_W-1:0] lat_field;
  logic          len_ok, order_ok, lat_ok, accept;

  assign len_code  = fields[2:0];
  assign lat_field = fields[LAT_LSB +: CL_W];
  assign len_ok    = (len_code == LEN4_CODE) || (len_code == LEN8_CODE);
  assign order_ok  = !fields[ORDER_BIT];
  assign lat_ok    = (32'(lat_field) >= CL_MIN) && (32'(lat_field) <= CL_MAX);
  assign accept    = set_en && !busy && len_ok && order_ok && lat_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      len8 <= 1'b0;
      lat  <= CL_W'(CL_MIN);
      err  <= 1'b0;
    end else begin
      err <= set_en && !accept;
      if (accept) begin
        len8 <= (len_code == LEN8_CODE);
        lat  <= lat_field;
      end
    end
  end

  // R2: the held latency never leaves the legal range
  p_lat_range_r2: assert property (@(posedge clk) disable iff (rst)
    (32'(lat) >= CL_MIN) && (32'(lat) <= CL_MAX));

  // R3/R10: a refused mode-set leaves the mode untouched
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(len8) && $stable(lat)));
endmodule

// File: rtl/rbs_launch_pipe.sv
module rbs_launch_pipe #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned DEPTH = 7,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [COL_W-1:0] load_col,
  output logic             launch,
  output logic [COL_W-1:0] launch_col,
  output logic             pending
);
  logic [DEPTH-1:0] v_q;
  logic [COL_W-1:0] c_q [DEPTH];
  logic [DEPTH-1:0] v_shift;

  assign v_shift = v_q >> 1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic             nxt_v;
    logic [COL_W-1:0] nxt_c;
    if (g == DEPTH - 1) begin : g_top
      assign nxt_v = 1'b0;
      assign nxt_c = '0;
    end else begin : g_mid
      assign nxt_v = v_q[g+1];
      assign nxt_c = c_q[g+1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[g] <= 1'b0;
        c_q[g] <= '0;
      end else if (load && (32'(load_idx) == g)) begin
        v_q[g] <= 1'b1;
        c_q[g] <= load_col;
      end else begin
        v_q[g] <= nxt_v;
        c_q[g] <= nxt_c;
      end
    end
  end

  assign launch     = v_q[0];
  assign launch_col = c_q[0];
  assign pending    = |v_q;

  // R4: a new entry never lands on a slot still carrying an older read
  p_no_collide_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> !v_shift[load_idx]);
endmodule

// File: rtl/rbs_beat_gen.sv
module rbs_beat_gen #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              len8,
  input  logic [DATA_W-1:0] din,
  output logic [COL_W-1:0]  col,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              more
);
  logic [COL_W-1:0] base_q;
  logic [2:0]       idx_q, left_q;
  logic             len8_q, first_q, armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      len8_q  <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
      first_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (start) begin
        base_q  <= start_col;
        len8_q  <= len8;
        idx_q   <= len8 ? {start_col[2], 2'b00} : 3'b000;
        left_q  <= len8 ? 3'd7 : 3'd3;
        valid   <= 1'b1;
        data    <= din;
        first_q <= 1'b1;
      end else if (left_q != 3'd0) begin
        idx_q   <= idx_q + 3'd1;
        left_q  <= left_q - 3'd1;
        valid   <= 1'b1;
        data    <= din;
        first_q <= 1'b0;
      end else begin
        valid   <= 1'b0;
        data    <= '0;
        first_q <= 1'b0;
      end
    end
  end

  assign col  = len8_q ? {base_q[COL_W-1:3], idx_q} : {base_q[COL_W-1:2], idx_q[1:0]};
  assign more = (left_q != 3'd0);

  // R7: within one burst the bits above the block never move
  p_upper_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (armed_q && valid && !first_q) |-> (col[COL_W-1:3] == $past(col[COL_W-1:3])));
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CL_W   = 3,
  parameter int unsigned CL_MIN = 4,
  parameter int unsigned CL_MAX = 7,
  localparam int unsigned IDX_W = $clog2(CL_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] rd_din,
  output logic [COL_W-1:0]  beat_col,
  output logic [DATA_W-1:0] beat_data,
  output logic              beat_valid,
  output logic              mode_err,
  output logic              read_err
);
  import rbs_pkg::*;

  logic            is_mode, is_read, rd_ok, len8, launch, pending, more;
  logic [CL_W-1:0] lat;
  logic [2:0]      gap_q;
  logic [COL_W-1:0] launch_col, req_col;
  logic [IDX_W-1:0] slot;

  assign is_mode = cmd_valid && (cmd_op == OP_MODE);
  assign is_read = cmd_valid && (cmd_op == OP_READ);
  assign rd_ok   = is_read && (gap_q == 3'd0);
  assign req_col = {cmd_addr[COL_W-1:2], 2'b00};
  assign slot    = IDX_W'(lat - CL_W'(1));

  rbs_mode_reg #(.ADDR_W(ADDR_W), .CL_W(CL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX)) u_mode (
    .clk(clk), .rst(rst), .set_en(is_mode), .busy(pending || more),
    .fields(cmd_addr), .len8(len8), .lat(lat), .err(mode_err)
  );

  rbs_launch_pipe #(.COL_W(COL_W), .DEPTH(CL_MAX)) u_pipe (
    .clk(clk), .rst(rst), .load(rd_ok), .load_idx(slot), .load_col(req_col),
    .launch(launch), .launch_col(launch_col), .pending(pending)
  );

  rbs_beat_gen #(.COL_W(COL_W), .DATA_W(DATA_W)) u_beat (
    .clk(clk), .rst(rst), .start(launch), .start_col(launch_col), .len8(len8),
    .din(rd_din), .col(beat_col), .data(beat_data), .valid(beat_valid), .more(more)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q    <= '0;
      read_err <= 1'b0;
    end else begin
      read_err <= is_read && !rd_ok;
      if (rd_ok)               gap_q <= len8 ? 3'd7 : 3'd3;
      else if (gap_q != 3'd0)  gap_q <= gap_q - 3'd1;
    end
  end

  // R9: a READ inside the previous burst window is answered with read_err
  p_read_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (is_read && (gap_q != 3'd0)) |=> read_err);
endmodule

// File: tb/tb_rd_burst_seq.sv
module tb_rd_burst_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [11:0] cmd_addr = '0;
  logic [15:0] rd_din = 16'h3C00;
  logic [8:0]  beat_col;
  logic [15:0] beat_data;
  logic        beat_valid, mode_err, read_err;
  logic [15:0] prev_din;
  int          tests = 0, fails = 0;

  always #4 clk = ~clk;

  rd_burst_seq dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .rd_din(rd_din), .beat_col(beat_col), .beat_data(beat_data),
    .beat_valid(beat_valid), .mode_err(mode_err), .read_err(read_err)
  );

  // {len8, latency[2:0], column[8:0]}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 3'd4, 9'h0A3}, {1'b1, 3'd5, 9'h012}, {1'b1, 3'd7, 9'h1F6},
    {1'b0, 3'd6, 9'h155}, {1'b1, 3'd4, 9'h004}, {1'b1, 3'd6, 9'h0FB}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    prev_din = rd_din;
    @(posedge clk);
    #1;
    rd_din = rd_din + 16'h0107;
  endtask

  task automatic issue(input logic [1:0] op, input logic [11:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    tick();
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0;
  endtask

  function automatic logic [11:0] mode_word(input bit l8, input int lat);
    return {5'b0, 3'(lat), 1'b0, (l8 ? 3'b011 : 3'b010)};
  endfunction

  function automatic logic [8:0] exp_col(input logic [8:0] c, input bit l8, input int k);
    logic [2:0] s;
    if (l8) begin
      s = {c[2], 2'b00} + 3'(k);
      return {c[8:3], s};
    end
    return {c[8:2], 2'(k)};
  endfunction

  // Checks one burst; returns when its last beat is visible.
  task automatic read_check(input logic [8:0] c, input bit l8, input int lat, input string tag);
    int early = 0;
    issue(2'd2, {3'b0, c});
    for (int k = 1; k < lat; k++) begin
      tick();
      if (beat_valid) early++;
    end
    check(early == 0, {"R4 quiet before latency ", tag}, early, 0);
    for (int b = 0; b < (l8 ? 8 : 4); b++) begin
      tick();
      check(beat_valid, {"R8 beat valid ", tag}, beat_valid, 1);
      check(beat_col == exp_col(c, l8, b), {"R5/R6/R7 column ", tag},
            beat_col, exp_col(c, l8, b));
      check(beat_data == prev_din, {"R11 data ", tag}, beat_data, prev_din);
    end
  endtask

  task automatic expect_end(input string tag);
    tick();
    check(!beat_valid && beat_data == 16'h0, {"R8/R11 burst end ", tag}, beat_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state and default mode
    check(!beat_valid && !mode_err && !read_err, "R1 reset outputs",
          {beat_valid, mode_err, read_err}, 0);
    read_check(9'h1AE, 1'b0, 4, "R1 default mode");
    expect_end("R1");

    // Vector table: mode-set then read
    for (int i = 0; i < 6; i++) begin
      issue(2'd1, mode_word(VEC[i][12], int'(VEC[i][11:9])));
      check(!mode_err, "R2 legal mode-set", mode_err, 0);
      read_check(VEC[i][8:0], VEC[i][12], int'(VEC[i][11:9]), "vector");
      expect_end("vector");
    end

    // R3: reserved encodings refused, BL8 latency 5 kept
    issue(2'd1, mode_word(1'b1, 5));
    issue(2'd1, 12'h057);
    check(mode_err, "R3 reserved length", mode_err, 1);
    issue(2'd1, 12'h05B);
    check(mode_err, "R3 interleave", mode_err, 1);
    issue(2'd1, 12'h032);
    check(mode_err, "R3 latency 3", mode_err, 1);
    tick();
    check(!mode_err, "R3 single pulse", mode_err, 0);
    read_check(9'h0CD, 1'b1, 5, "R3 mode kept");
    expect_end("R3");

    // R9: gapless back-to-back, BL4 latency 4
    issue(2'd1, mode_word(1'b0, 4));
    issue(2'd2, 12'h048);
    repeat (3) tick();
    issue(2'd2, 12'h0B1);
    check(!read_err, "R9 gapless accepted", read_err, 0);
    for (int b = 0; b < 8; b++) begin
      if (b > 0) tick();
      check(beat_valid && beat_col == (b < 4 ? exp_col(9'h048, 0, b) : exp_col(9'h0B1, 0, b - 4)),
            "R9 gapless column", beat_col,
            b < 4 ? exp_col(9'h048, 0, b) : exp_col(9'h0B1, 0, b - 4));
    end
    expect_end("R9 gapless");

    // R9: early read refused
    repeat (3) tick();
    issue(2'd2, 12'h020);
    tick();
    issue(2'd2, 12'h1C0);
    check(read_err, "R9 early read refused", read_err, 1);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (beat_valid) begin
        cnt++;
        check(beat_col[8:2] == 7'(9'h020 >> 2), "R9 no beats from refused read", beat_col, 9'h020);
      end
    end
    check(cnt == 4, "R9 beat count", cnt, 4);

    // R10: mode-set while in flight refused
    issue(2'd2, 12'h140);
    issue(2'd1, mode_word(1'b1, 7));
    check(mode_err, "R10 busy mode-set", mode_err, 1);
    repeat (8) tick();
    read_check(9'h07A, 1'b0, 4, "R10 mode kept");
    expect_end("R10");

    // R12: command with strobe low ignored
    cmd_valid = 1'b0; cmd_op = 2'd2; cmd_addr = 12'h0F0;
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (beat_valid || read_err || mode_err) cnt++;
    end
    cmd_op = 2'd1; cmd_addr = 12'h057;
    tick();
    if (mode_err) cnt++;
    cmd_op = 2'd0; cmd_addr = '0;
    check(cnt == 0, "R12 strobe low no effect", cnt, 0);
    read_check(9'h133, 1'b0, 4, "R12 mode kept");
    expect_end("R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule